// File: doc/BRIEF.md
# Clock Generator Configuration Write Receiver

This block is a write-only slave on a two-wire serial bus. Configuration for a clock generator comes in through it. Both bus lines are brought into the system clock domain, and the block watches them for start and stop conditions. It shifts in each byte and keeps count of where that byte sits in a fixed frame of eleven bytes.

The frame holds these bytes in sequence:

1. A slave address.
2. A command byte.
3. A count byte.
4. Eight payload bytes.

Six configuration bytes are presented as one parallel bus. Only the first six payload bytes are stored in them, and each is stored only if the address byte matched. The command byte, the count byte and the last two payload bytes are still clocked through so that byte positions stay aligned, but nothing keeps them.

After reset the configuration bytes hold parameter defaults, so a system that never writes over the bus still has a working configuration. The block signals acknowledge by requesting a pull-low of the data line, which an external open-drain pad performs.

Top module: `clk_cfg_rx`

## Requirements
- R1: After reset, `cfgRegs` equals the `REG_RESET` parameter and `sdaPullLow` is 0.
- R2: Frame start is recognised as SDA falling while SCL is high. Frame stop is recognised as SDA rising while SCL is high. A stop always releases `sdaPullLow`.
- R3: Bits are sampled on SCL rising edges, most significant bit first.
- R4: The first byte after a start must equal 8'hD2 in all eight bits, direction bit included. With any other value, no configuration byte changes for the rest of that frame.
- R5: Byte positions 2 and 3 of a frame (counting the address as 1) carry no effect. Payload byte k, for k from 0 to 5, lands in `cfgRegs[8k+7:8k]`.
- R6: Payload bytes 6 and 7 are received and discarded.
- R7: Once the address has matched, the block pulls SDA low during the ninth SCL pulse of every byte in positions 1 to 11. It never does so after a mismatched address.
- R8: A start or a stop part way through a frame resets the byte position. Configuration bytes already written keep their new values.
- R9: Bytes beyond the eleventh in a frame are neither stored nor acknowledged until the next start.
- R10: A payload byte becomes visible on `cfgRegs` three system clocks after the SCL rise that carries its eighth bit, before the acknowledge pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaPullLow | output | 1 | Drive the data line low (acknowledge) |
| cfgRegs | output | 48 | Six configuration bytes, byte k at bits 8k+7:8k |

## Verification
Two situations are hard to reach from the ports. The first is a frame broken off part way: a stop after two stored payload bytes, or a repeated start that arrives while the header is still being counted. The bench drives these with its own bus-level start, stop and bit tasks, and its frame model checks that earlier writes survive and that counting starts again from the address. The second is a trailing byte after the eleventh. The bench sends two such bytes and checks that neither raises an acknowledge nor touches the register image. Addresses that differ from the match value only in the direction bit, or only in the MSB, test the full-byte compare and the bit order.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;

  // Synchronised bus events, one system clock wide each
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
  } busEvt_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic shiftEn;
    logic regWrEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/clk_cfg_dp.sv
module clk_cfg_dp
  import clk_cfg_pkg::*;
#(
  parameter logic [7:0] SLAVE_ADDR = 8'hD2,
  parameter int NUM_REGS = 6,
  parameter int CNT_W = 4,
  parameter logic [8*NUM_REGS-1:0] REG_RESET = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdaIn,
  input  logic                  sclIn,
  input  ctrlStrobe_t           strobe,
  input  logic [CNT_W-1:0]      wrIdx,
  output busEvt_t               evt,
  output logic                  addrMatch,
  output logic [8*NUM_REGS-1:0] cfgRegs
);

  logic [1:0] sdaSync, sclSync;
  logic sdaD, sclD;
  logic sdaS, sclS;
  logic [7:0] shiftReg;
  logic [7:0] newByte;

  assign sdaS = sdaSync[1];
  assign sclS = sclSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaSync <= 2'b11;
      sclSync <= 2'b11;
      sdaD    <= 1'b1;
      sclD    <= 1'b1;
    end else begin
      sdaSync <= {sdaSync[0], sdaIn};
      sclSync <= {sclSync[0], sclIn};
      sdaD    <= sdaS;
      sclD    <= sclS;
    end
  end

  always_comb begin
    evt.start   = sclS & sclD & sdaD & ~sdaS;
    evt.stop    = sclS & sclD & ~sdaD & sdaS;
    evt.sclRise = sclS & ~sclD;
    evt.sclFall = ~sclS & sclD;
  end

  // The byte as it stands once the incoming bit is appended
  assign newByte   = {shiftReg[6:0], sdaS};
  assign addrMatch = (newByte == SLAVE_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= newByte;
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic [7:0] regQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regQ <= REG_RESET[8*k +: 8];
      else if (strobe.regWrEn && wrIdx == CNT_W'(k)) regQ <= newByte;
    end
    assign cfgRegs[8*k +: 8] = regQ;
  end

endmodule

// File: rtl/clk_cfg_ctrl.sv
module clk_cfg_ctrl
  import clk_cfg_pkg::*;
#(
  parameter int FRAME_BYTES = 11,
  parameter int HDR_BYTES = 3,
  parameter int NUM_REGS = 6,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  busEvt_t          evt,
  input  logic             addrMatch,
  output ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] wrIdx,
  output logic [CNT_W-1:0] byteCnt,
  output logic [3:0]       bitCnt,
  output logic             addrOk,
  output logic             ackOn
);

  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_BYTES);
  localparam logic [CNT_W-1:0] REG_FIRST = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] REG_LAST  = CNT_W'(HDR_BYTES + NUM_REGS - 1);

  logic active;
  logic inFrame;
  logic lastBit;

  assign inFrame = active && (byteCnt < FRAME_END);
  assign lastBit = (bitCnt == 4'd7);
  assign wrIdx   = byteCnt - REG_FIRST;

  always_comb begin
    strobe.shiftEn = inFrame && evt.sclRise && (bitCnt < 4'd8);
    strobe.regWrEn = strobe.shiftEn && lastBit && addrOk &&
                     (byteCnt >= REG_FIRST) && (byteCnt <= REG_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      bitCnt  <= '0;
      byteCnt <= '0;
      addrOk  <= 1'b0;
      ackOn   <= 1'b0;
    end else if (evt.start) begin
      active  <= 1'b1;
      bitCnt  <= '0;
      byteCnt <= '0;
      addrOk  <= 1'b0;
      ackOn   <= 1'b0;
    end else if (evt.stop) begin
      active  <= 1'b0;
      bitCnt  <= '0;
      byteCnt <= '0;
      addrOk  <= 1'b0;
      ackOn   <= 1'b0;
    end else if (active) begin
      if (inFrame && evt.sclRise) begin
        if (bitCnt == 4'd8) begin
          bitCnt  <= '0;
          byteCnt <= byteCnt + 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
          if (lastBit && byteCnt == '0) addrOk <= addrMatch;
        end
      end
      if (evt.sclFall)
        ackOn <= (bitCnt == 4'd8) && addrOk && (byteCnt < FRAME_END);
    end
  end

endmodule

// File: rtl/clk_cfg_rx.sv
module clk_cfg_rx
  import clk_cfg_pkg::*;
#(
  parameter logic [7:0] SLAVE_ADDR = 8'hD2,
  parameter int FRAME_BYTES = 11,
  parameter int HDR_BYTES = 3,
  parameter int NUM_REGS = 6,
  parameter logic [8*NUM_REGS-1:0] REG_RESET = 48'h81_0F_3C_A5_00_FF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdaIn,
  input  logic                  sclIn,
  output logic                  sdaPullLow,
  output logic [8*NUM_REGS-1:0] cfgRegs
);

  localparam int CNT_W = $clog2(FRAME_BYTES + 1);

  busEvt_t          evt;
  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] wrIdx;
  logic [CNT_W-1:0] byteCnt;
  logic [3:0]       bitCnt;
  logic             addrOk;
  logic             addrMatch;

  clk_cfg_dp #(
    .SLAVE_ADDR(SLAVE_ADDR), .NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .REG_RESET(REG_RESET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .sclIn(sclIn), .strobe(strobe),
    .wrIdx(wrIdx), .evt(evt), .addrMatch(addrMatch), .cfgRegs(cfgRegs)
  );

  clk_cfg_ctrl #(
    .FRAME_BYTES(FRAME_BYTES), .HDR_BYTES(HDR_BYTES), .NUM_REGS(NUM_REGS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .addrMatch(addrMatch), .strobe(strobe),
    .wrIdx(wrIdx), .byteCnt(byteCnt), .bitCnt(bitCnt), .addrOk(addrOk), .ackOn(sdaPullLow)
  );

endmodule

// File: rtl/clk_cfg_rx_chk.sv
module clk_cfg_rx_chk
  import clk_cfg_pkg::*;
#(
  parameter int FRAME_BYTES = 11,
  parameter int HDR_BYTES = 3,
  parameter int NUM_REGS = 6,
  parameter int CNT_W = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input busEvt_t               evt,
  input ctrlStrobe_t           strobe,
  input logic [CNT_W-1:0]      byteCnt,
  input logic [3:0]            bitCnt,
  input logic                  addrOk,
  input logic                  sdaPullLow,
  input logic [8*NUM_REGS-1:0] cfgRegs
);

  AST_REG_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgRegs) |-> $past(strobe.regWrEn)); // R4

  AST_WRITE_IN_PAYLOAD_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.regWrEn |-> (byteCnt >= CNT_W'(HDR_BYTES)) &&
                       (byteCnt < CNT_W'(HDR_BYTES + NUM_REGS))); // R5

  AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    sdaPullLow |-> addrOk); // R7

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    evt.stop |=> !sdaPullLow); // R2

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    evt.start |=> (byteCnt == '0) && (bitCnt == 4'd0) && !addrOk); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (byteCnt <= CNT_W'(FRAME_BYTES)) && (bitCnt <= 4'd8)); // R9

endmodule

bind clk_cfg_rx clk_cfg_rx_chk #(
  .FRAME_BYTES(FRAME_BYTES), .HDR_BYTES(HDR_BYTES), .NUM_REGS(NUM_REGS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .evt(evt), .strobe(strobe), .byteCnt(byteCnt),
  .bitCnt(bitCnt), .addrOk(addrOk), .sdaPullLow(sdaPullLow), .cfgRegs(cfgRegs)
);

// File: tb/clk_cfg_rx_tb.sv
`timescale 1ns/1ps
module clk_cfg_rx_tb;

  localparam logic [47:0] DEF = 48'h81_0F_3C_A5_00_FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sdaM = 1'b1;
  logic sclM = 1'b1;
  logic sdaPullLow;
  logic [47:0] cfgRegs;
  logic sdaLine;

  int tests = 0;
  int fails = 0;
  int holdoff = 0;
  int byteIdx = 0;
  bit addrGood = 1'b0;
  bit compareOn = 1'b0;
  logic [47:0] expImg;

  assign sdaLine = sdaM & ~sdaPullLow;

  always #2.5 clk = ~clk;

  clk_cfg_rx #(.REG_RESET(DEF)) u_dut (
    .clk(clk), .rstN(rstN), .sdaIn(sdaLine), .sclIn(sclM),
    .sdaPullLow(sdaPullLow), .cfgRegs(cfgRegs)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitH;
    repeat (8) @(posedge clk);
    #1;
  endtask

  // Register image compared on every clock once writes have settled
  always @(negedge clk) begin
    if (rstN && compareOn) begin
      if (holdoff > 0) holdoff--;
      else check("R4 R5 R6 R8 R10 register image", cfgRegs, expImg);
    end
  end

  task automatic busStart;          // also serves as a repeated start
    sdaM = 1'b1; waitH;
    sclM = 1'b1; waitH;
    sdaM = 1'b0; waitH;
    sclM = 1'b0; waitH;
    byteIdx = 0;
    addrGood = 1'b0;
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitH;
    sclM = 1'b1; waitH;
    sdaM = 1'b1; waitH;
    byteIdx = 0;
    addrGood = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    bit ackExp;
    ackExp = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitH;
      sclM = 1'b1;
      if (i == 0) begin
        // frame model: commit on the eighth bit
        if (byteIdx < 11) begin
          if (byteIdx == 0) addrGood = (b == 8'hD2);
          else if (addrGood && byteIdx >= 3 && byteIdx <= 8) begin
            expImg[8*(byteIdx-3) +: 8] = b;
            holdoff = 8;
          end
          ackExp = addrGood;
        end
        byteIdx++;
      end
      waitH;
      sclM = 1'b0; waitH;
    end
    sdaM = 1'b1; waitH;
    sclM = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    if (byteIdx > 11) check("R9 no ack past frame", {47'd0, sdaPullLow}, 48'd0);
    else check("R7 acknowledge", {47'd0, sdaPullLow}, {47'd0, ackExp});
    waitH;
    sclM = 1'b0; waitH;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    expImg = DEF;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset image", cfgRegs, DEF);
    check("R1 reset no pull", {47'd0, sdaPullLow}, 48'd0);
    compareOn = 1'b1;

    // Full good frame, command/count arbitrary, payload 6 and 7 dropped (R5 R6 R3)
    busStart;
    sendByte(8'hD2); sendByte(8'h5A); sendByte(8'h08);
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h33);
    sendByte(8'h44); sendByte(8'h55); sendByte(8'h66);
    sendByte(8'h77); sendByte(8'h88);
    busStop;
    check("R2 released after stop", {47'd0, sdaPullLow}, 48'd0);

    // Direction bit set: mismatch, no writes, no ack (R4 R7)
    busStart;
    sendByte(8'hD3); sendByte(8'h00); sendByte(8'h00);
    for (int k = 0; k < 8; k++) sendByte(8'hE0 + 8'(k));
    busStop;

    // MSB flipped: mismatch, exercises bit order (R3 R4)
    busStart;
    sendByte(8'h52); sendByte(8'hFF); sendByte(8'hFF);
    for (int k = 0; k < 8; k++) sendByte(8'h00);
    busStop;

    // Stop after two payload bytes: those stay (R8)
    busStart;
    sendByte(8'hD2); sendByte(8'h01); sendByte(8'h02);
    sendByte(8'hA1); sendByte(8'hA2);
    busStop;

    // Repeated start inside the header, then a full frame plus trailing bytes (R8 R9)
    busStart;
    sendByte(8'hD2); sendByte(8'h03);
    busStart;
    sendByte(8'hD2); sendByte(8'hFF); sendByte(8'h00);
    sendByte(8'h00); sendByte(8'hFF); sendByte(8'hB3);
    sendByte(8'hB4); sendByte(8'hB5); sendByte(8'hB6);
    sendByte(8'hC7); sendByte(8'hC8);
    sendByte(8'hC9); sendByte(8'hCA);
    busStop;

    repeat (20) @(posedge clk);
    #1;
    check("R5 final image", cfgRegs, 48'hB6_B5_B4_B3_FF_00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule